// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block moves received frame bytes into host memory through a ring of two-word descriptors. Each descriptor names one fixed-size receive buffer of 128 bytes. When a frame starts, the block reads the descriptor's address word through a word-wide read port. It packs the incoming bytes into 32-bit words and stores them in the buffer. After the buffer's data, it writes the status word and then the address word, with the ownership bit set, so that the buffer passes to software. A frame longer than one buffer continues in the next descriptor. A descriptor whose wrap bit is set sends the pointer back to the ring base.

Software hands a buffer back by clearing bit 0 of its address word in memory. If the block meets a descriptor that software still holds, it discards the rest of the frame and raises a sticky overrun flag. The next frame reads the same descriptor again, so a buffer that software has released in the meantime is picked up. Address filtering is done elsewhere, and its results arrive as match flags with the last byte of the frame. A register write sets the ring base.

Top module: `rx_ring_writer`

## Requirements
- R1: While reset is held, and until a frame byte is offered after reset, inReady, memRdEn and memWrEn are low and ovrFlag is 0.
- R2: When a byte is offered while the block is idle, it reads the address word at the current descriptor pointer. The buffer address is bits 31:2 of that word, with the two low bits taken as zero.
- R3: Bytes are packed little-endian, the first byte of a word in bits 7:0, into words stored at consecutive word addresses of the buffer. A final partial word has zero in its unused bytes.
- R4: A buffer takes at most 128 bytes. The 129th byte of a frame goes to the buffer of the next descriptor, which sits 8 bytes further on.
- R5: The status word, at descriptor address + 4, is written only after all data words of that buffer. Bit 14 is set in the first buffer of a frame and bit 15 in the last buffer.
- R6: Status bits 11:0 hold the total frame length in the last buffer and are zero in every other buffer.
- R7: Match flags are taken on the last byte and reported only in the last buffer's status word. Broadcast goes in bit 31, type match in bit 22, and address slots 1, 2, 3 and 4 in bits 26, 25, 24 and 23.
- R8: After the status word, the address word is written back with bit 0 set, and with bit 1 and the address bits unchanged.
- R9: After a descriptor whose address word has bit 1 set, the next descriptor used is the one at the ring base.
- R10: A descriptor read with bit 0 set gets no writes. The rest of the frame is accepted and discarded, and ovrFlag goes to 1. ovrFlag stays set until ovrClr is pulsed, and the next frame reads the same descriptor again.
- R11: A write on baseWe loads the ring base with baseData bits 2:0 forced to zero, and moves the descriptor pointer to that base.
- R12: A byte is taken only in a cycle where inReady is high, and inReady is low in every cycle that reads or writes memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseWe | input | 1 | Ring base write strobe |
| baseData | input | 32 | New ring base byte address |
| inValid | input | 1 | Stream byte valid |
| inData | input | 8 | Stream byte |
| inLast | input | 1 | Last byte of the frame |
| inBcast | input | 1 | Broadcast destination flag, valid with inLast |
| inAddrHit | input | 4 | Address slot matches, bit 0 = slot 1, valid with inLast |
| inTypeHit | input | 1 | Type-ID match flag, valid with inLast |
| inReady | output | 1 | Byte accepted at this edge when inValid is high |
| memRdEn | output | 1 | Memory read strobe |
| memRdAddr | output | 32 | Memory read byte address |
| memRdData | input | 32 | Read data, valid one cycle after memRdEn |
| memWrEn | output | 1 | Memory write strobe |
| memWrAddr | output | 32 | Memory write byte address |
| memWrData | output | 32 | Memory write data |
| ovrClr | input | 1 | Clears the overrun flag |
| ovrFlag | output | 1 | Sticky overrun flag |

## Verification
Once a word's fourth byte or a frame's last byte is accepted, the data word is written on the next cycle, the status word on the cycle after, and the address word on the cycle after that. The bench therefore waits ten cycles after the last byte before it compares the whole memory image with a model built from the requirements. inReady depends only on the control state, so the bench reads it at the falling edge and knows which rising edge takes the byte. A refused descriptor sets the overrun flag two cycles after the first byte is offered, well before the bench samples it after the frame.

// File: rtl/rdw_pkg.sv
package rdw_pkg;
  localparam int STAT_LEN_W   = 12;
  localparam int STAT_SOF     = 14;
  localparam int STAT_EOF     = 15;
  localparam int STAT_TYPE    = 22;
  localparam int STAT_SLOT_LO = 23;
  localparam int NUM_SLOTS    = 4;
  localparam int STAT_BCAST   = 31;
  localparam int DESC_BYTES   = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_DATA, S_WORD, S_STAT, S_OWN, S_DROP
  } rdwState_t;

  typedef struct packed {
    logic fetch;
    logic loadDesc;
    logic takeByte;
    logic writeWord;
    logic writeStat;
    logic writeOwn;
    logic frameStart;
    logic setOvr;
  } rdwStrobe_t;
endpackage

// File: rtl/rdw_ctrl.sv
module rdw_ctrl
  import rdw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inLast,
  input  logic       descOwned,
  input  logic       laneLast,
  input  logic       wordFinal,
  input  logic       frameDone,
  output logic       inReady,
  output rdwStrobe_t stb
);
  rdwState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    stb       = '0;
    inReady   = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (inValid) begin
          stb.frameStart = 1'b1;
          stateNext      = S_FETCH;
        end
      end
      S_FETCH: begin
        stb.fetch = 1'b1;
        stateNext = S_CHECK;
      end
      S_CHECK: begin
        if (descOwned) begin
          stb.setOvr = 1'b1;
          stateNext  = S_DROP;
        end else begin
          stb.loadDesc = 1'b1;
          stateNext    = S_DATA;
        end
      end
      S_DATA: begin
        inReady = 1'b1;
        if (inValid) begin
          stb.takeByte = 1'b1;
          if (inLast || laneLast) stateNext = S_WORD;
        end
      end
      S_WORD: begin
        stb.writeWord = 1'b1;
        stateNext = (frameDone || wordFinal) ? S_STAT : S_DATA;
      end
      S_STAT: begin
        stb.writeStat = 1'b1;
        stateNext     = S_OWN;
      end
      S_OWN: begin
        stb.writeOwn = 1'b1;
        stateNext    = frameDone ? S_IDLE : S_FETCH;
      end
      S_DROP: begin
        inReady = 1'b1;
        if (inValid && inLast) stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end
endmodule

// File: rtl/rdw_datapath.sv
module rdw_datapath
  import rdw_pkg::*;
#(
  parameter int BUF_BYTES = 128
)(
  input  logic        clk,
  input  logic        rstN,
  input  rdwStrobe_t  stb,
  input  logic        baseWe,
  input  logic [31:0] baseData,
  input  logic [7:0]  inData,
  input  logic        inLast,
  input  logic        inBcast,
  input  logic [NUM_SLOTS-1:0] inAddrHit,
  input  logic        inTypeHit,
  input  logic [31:0] memRdData,
  input  logic        ovrClr,
  output logic        memRdEn,
  output logic [31:0] memRdAddr,
  output logic        memWrEn,
  output logic [31:0] memWrAddr,
  output logic [31:0] memWrData,
  output logic        ovrFlag,
  output logic        descOwned,
  output logic        laneLast,
  output logic        wordFinal,
  output logic        frameDone
);
  localparam int WORDS = BUF_BYTES / 4;
  localparam int OFF_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [31:0]           ringBase, descPtr;
  logic [29:0]           bufHi;
  logic                  wrapBit;
  logic [31:0]           wordReg;
  logic [1:0]            lane;
  logic [OFF_W-1:0]      wordOff;
  logic [STAT_LEN_W-1:0] frameLen;
  logic                  sofPend;
  logic                  hitBcast, hitType;
  logic [NUM_SLOTS-1:0]  hitSlot, slotField;
  logic [31:0]           statWord, wordAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ringBase  <= '0;
      descPtr   <= '0;
      bufHi     <= '0;
      wrapBit   <= 1'b0;
      wordReg   <= '0;
      lane      <= '0;
      wordOff   <= '0;
      frameLen  <= '0;
      sofPend   <= 1'b0;
      frameDone <= 1'b0;
      hitBcast  <= 1'b0;
      hitType   <= 1'b0;
      hitSlot   <= '0;
      ovrFlag   <= 1'b0;
    end else begin
      if (baseWe) begin
        ringBase <= {baseData[31:3], 3'b000};
        descPtr  <= {baseData[31:3], 3'b000};
      end else if (stb.writeOwn) begin
        descPtr <= wrapBit ? ringBase : descPtr + 32'(DESC_BYTES);
      end
      if (stb.loadDesc) begin
        bufHi   <= memRdData[31:2];
        wrapBit <= memRdData[1];
        wordReg <= '0;
        lane    <= '0;
        wordOff <= '0;
      end
      if (stb.frameStart) begin
        sofPend   <= 1'b1;
        frameDone <= 1'b0;
        frameLen  <= '0;
      end
      if (stb.takeByte) begin
        wordReg[{lane, 3'b000} +: 8] <= inData;
        lane     <= lane + 2'd1;
        frameLen <= frameLen + 1'b1;
        if (inLast) begin
          frameDone <= 1'b1;
          hitBcast  <= inBcast;
          hitType   <= inTypeHit;
          hitSlot   <= inAddrHit;
        end
      end
      if (stb.writeWord) begin
        wordReg <= '0;
        lane    <= '0;
        wordOff <= wordOff + 1'b1;
      end
      if (stb.writeStat) sofPend <= 1'b0;
      if (stb.setOvr)    ovrFlag <= 1'b1;
      else if (ovrClr)   ovrFlag <= 1'b0;
    end
  end

  // slot 1 sits in the highest bit of the slot field
  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    assign slotField[NUM_SLOTS-1-k] = hitSlot[k];
  end

  always_comb begin
    statWord           = '0;
    statWord[STAT_SOF] = sofPend;
    if (frameDone) begin
      statWord[STAT_EOF]                         = 1'b1;
      statWord[STAT_LEN_W-1:0]                   = frameLen;
      statWord[STAT_BCAST]                       = hitBcast;
      statWord[STAT_TYPE]                        = hitType;
      statWord[STAT_SLOT_LO +: NUM_SLOTS]        = slotField;
    end
  end

  assign wordAddr  = {bufHi, 2'b00} + (32'(wordOff) << 2);
  assign descOwned = memRdData[0];
  assign laneLast  = (lane == 2'd3);
  assign wordFinal = (wordOff == OFF_W'(WORDS - 1));
  assign memRdEn   = stb.fetch;
  assign memRdAddr = descPtr;

  always_comb begin
    memWrEn   = 1'b0;
    memWrAddr = '0;
    memWrData = '0;
    if (stb.writeWord) begin
      memWrEn   = 1'b1;
      memWrAddr = wordAddr;
      memWrData = wordReg;
    end else if (stb.writeStat) begin
      memWrEn   = 1'b1;
      memWrAddr = descPtr + 32'd4;
      memWrData = statWord;
    end else if (stb.writeOwn) begin
      memWrEn   = 1'b1;
      memWrAddr = descPtr;
      memWrData = {bufHi, wrapBit, 1'b1};
    end
  end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rdw_pkg::*;
#(
  parameter int BUF_BYTES = 128
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        baseWe,
  input  logic [31:0] baseData,
  input  logic        inValid,
  input  logic [7:0]  inData,
  input  logic        inLast,
  input  logic        inBcast,
  input  logic [3:0]  inAddrHit,
  input  logic        inTypeHit,
  output logic        inReady,
  output logic        memRdEn,
  output logic [31:0] memRdAddr,
  input  logic [31:0] memRdData,
  output logic        memWrEn,
  output logic [31:0] memWrAddr,
  output logic [31:0] memWrData,
  input  logic        ovrClr,
  output logic        ovrFlag
);
  rdwStrobe_t stb;
  logic descOwned, laneLast, wordFinal, frameDone;

  rdw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast),
    .descOwned(descOwned), .laneLast(laneLast), .wordFinal(wordFinal),
    .frameDone(frameDone), .inReady(inReady), .stb(stb)
  );

  rdw_datapath #(.BUF_BYTES(BUF_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .baseWe(baseWe), .baseData(baseData),
    .inData(inData), .inLast(inLast), .inBcast(inBcast), .inAddrHit(inAddrHit),
    .inTypeHit(inTypeHit), .memRdData(memRdData), .ovrClr(ovrClr),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memWrEn(memWrEn),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .ovrFlag(ovrFlag),
    .descOwned(descOwned), .laneLast(laneLast), .wordFinal(wordFinal),
    .frameDone(frameDone)
  );
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk
  import rdw_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        inReady,
  input logic        memRdEn,
  input logic        memWrEn,
  input logic [31:0] memWrData,
  input logic        ovrFlag,
  input logic        ovrClr,
  input rdwStrobe_t  stb
);
  // R12
  ready_no_mem_chk: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> !memWrEn && !memRdEn);

  // R5
  stat_after_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.writeStat |-> $past(stb.writeWord));

  // R8
  own_after_stat_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.writeOwn |-> $past(stb.writeStat) && memWrData[0]);

  // R10
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovrFlag && !ovrClr |=> ovrFlag);

  // R10
  refused_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.setOvr |=> !memWrEn && ovrFlag);

  // R2
  fetch_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn && !memWrEn);
endmodule

bind rx_ring_writer rx_ring_writer_chk u_chk (
  .clk(clk), .rstN(rstN), .inReady(inReady), .memRdEn(memRdEn),
  .memWrEn(memWrEn), .memWrData(memWrData), .ovrFlag(ovrFlag),
  .ovrClr(ovrClr), .stb(stb)
);

// File: tb/rx_ring_writer_tb.sv
module rx_ring_writer_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN, baseWe, inValid, inLast, inBcast, inTypeHit, ovrClr;
  logic [31:0] baseData;
  logic [7:0]  inData;
  logic [3:0]  inAddrHit;
  logic        inReady, memRdEn, memWrEn, ovrFlag;
  logic [31:0] memRdAddr, memRdData, memWrAddr, memWrData;

  rx_ring_writer u_dut (
    .clk(clk), .rstN(rstN), .baseWe(baseWe), .baseData(baseData),
    .inValid(inValid), .inData(inData), .inLast(inLast), .inBcast(inBcast),
    .inAddrHit(inAddrHit), .inTypeHit(inTypeHit), .inReady(inReady),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .ovrClr(ovrClr), .ovrFlag(ovrFlag)
  );

  int total = 0;
  int bad = 0;
  int clash = 0;
  logic [31:0] mem    [0:1023];
  logic [31:0] expMem [0:1023];
  logic [7:0]  fb     [0:4095];
  logic [31:0] expPtr, ringBase;
  int          ringN;
  logic        expOvr;

  always @(posedge clk) begin
    if (memWrEn) mem[memWrAddr[11:2]] <= memWrData;
    if (memRdEn) memRdData <= mem[memRdAddr[11:2]];
    if (rstN && inReady && (memWrEn || memRdEn)) clash++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] packWord(input int off, input int n);
    logic [31:0] w = '0;
    for (int b = 0; b < 4; b++)
      if (b < n) w[b*8 +: 8] = fb[off + b];
    return w;
  endfunction

  // model built from R2..R10
  task automatic applyFrame(input int len, input logic [5:0] flg);
    int off = 0;
    bit sof = 1'b1;
    while (off < len) begin
      logic [31:0] a, stat, bufA;
      int n;
      bit last;
      a = expMem[expPtr[11:2]];
      if (a[0]) begin
        expOvr = 1'b1;
        break;
      end
      bufA = {a[31:2], 2'b00};
      n = (len - off > 128) ? 128 : len - off;
      for (int w = 0; w < (n + 3) / 4; w++)
        expMem[bufA[11:2] + w] = packWord(off + 4*w, n - 4*w);
      last = (off + n == len);
      stat = '0;
      stat[14] = sof;
      stat[15] = last;
      if (last) begin
        stat[11:0] = len[11:0];
        stat[31] = flg[0];
        stat[26] = flg[1];
        stat[25] = flg[2];
        stat[24] = flg[3];
        stat[23] = flg[4];
        stat[22] = flg[5];
      end
      expMem[expPtr[11:2] + 1] = stat;
      expMem[expPtr[11:2]] = a | 32'd1;
      expPtr = a[1] ? ringBase : expPtr + 32'd8;
      sof = 1'b0;
      off += n;
    end
  endtask

  task automatic compareMem(input string what);
    int firstBad = -1;
    string req;
    for (int i = 0; i < 1024; i++)
      if (firstBad < 0 && mem[i] !== expMem[i]) firstBad = i;
    if (firstBad < 0) begin
      check(1'b1, "R3", what, 0, 0);
    end else begin
      if (firstBad >= int'(ringBase[11:2]) && firstBad < int'(ringBase[11:2]) + 2*ringN)
        req = ((firstBad - int'(ringBase[11:2])) % 2 == 0) ? "R8 R9 R10" : "R5 R6 R7";
      else
        req = "R3 R4";
      check(1'b0, req, $sformatf("%s word %0d", what, firstBad), mem[firstBad], expMem[firstBad]);
    end
  endtask

  task automatic setupRing(input logic [31:0] base, input int n, input logic [31:0] bufBase);
    for (int i = 0; i < n; i++) begin
      logic [31:0] a = bufBase + 32'(128 * i);
      if (i == n - 1) a[1] = 1'b1;
      mem[base[11:2] + 2*i]        = a;
      mem[base[11:2] + 2*i + 1]    = 32'hA5A5A5A5;
      expMem[base[11:2] + 2*i]     = a;
      expMem[base[11:2] + 2*i + 1] = 32'hA5A5A5A5;
    end
    ringBase = base;
    ringN    = n;
    expPtr   = base;
  endtask

  task automatic releaseAll();
    for (int i = 0; i < ringN; i++) begin
      mem[ringBase[11:2] + 2*i][0]    = 1'b0;
      expMem[ringBase[11:2] + 2*i][0] = 1'b0;
    end
  endtask

  task automatic writeBase(input logic [31:0] v);
    baseData = v;
    baseWe   = 1'b1;
    @(negedge clk);
    baseWe   = 1'b0;
  endtask

  task automatic sendFrame(input int len, input logic [5:0] flg);
    for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
    for (int i = 0; i < len; i++) begin
      if ($urandom_range(3, 0) == 0) begin
        inValid = 1'b0;
        @(negedge clk);
      end
      inValid = 1'b1;
      inData  = fb[i];
      inLast  = (i == len - 1);
      if (i == len - 1) {inTypeHit, inAddrHit, inBcast} = flg;
      else              {inTypeHit, inAddrHit, inBcast} = 6'($urandom);
      while (!inReady) @(negedge clk);
      @(negedge clk);
    end
    inValid = 1'b0;
    inLast  = 1'b0;
    applyFrame(len, flg);
    repeat (10) @(negedge clk);
    compareMem($sformatf("frame len %0d", len));
    check(ovrFlag === expOvr, "R10", "overrun flag", 32'(ovrFlag), 32'(expOvr));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lens[7] = '{1, 4, 5, 128, 129, 256, 3};
    logic [5:0] flgs[7] = '{6'b000001, 6'b000010, 6'b100000, 6'b010100, 6'b001001, 6'b111111, 6'b000000};
    logic [31:0] d;
    void'($urandom(32'd20240611));
    rstN = 1'b0; baseWe = 1'b0; baseData = '0; inValid = 1'b0; inData = '0;
    inLast = 1'b0; inBcast = 1'b0; inAddrHit = '0; inTypeHit = 1'b0; ovrClr = 1'b0;
    expOvr = 1'b0; ringBase = '0; ringN = 0; expPtr = '0;
    for (int i = 0; i < 1024; i++) begin mem[i] = '0; expMem[i] = '0; end
    repeat (3) @(negedge clk);
    check(inReady === 1'b0 && memWrEn === 1'b0 && memRdEn === 1'b0, "R1", "idle in reset",
          {29'd0, inReady, memWrEn, memRdEn}, 0);
    check(ovrFlag === 1'b0, "R1", "ovr in reset", 32'(ovrFlag), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(inReady === 1'b0 && memWrEn === 1'b0 && memRdEn === 1'b0, "R1", "idle after reset",
          {29'd0, inReady, memWrEn, memRdEn}, 0);

    // R11: ring at 0x100, six buffers at 0x400
    setupRing(32'h100, 6, 32'h400);
    writeBase(32'h100);

    // directed lengths: word edges, buffer edges, R9 wrap after six buffers
    for (int k = 0; k < 7; k++) begin
      d = expPtr;
      sendFrame(lens[k], flgs[k]);
      if (lens[k] == 5) begin
        check(mem[d[11:2] + 1][11:0] == 12'd5, "R6", "length field", 32'(mem[d[11:2] + 1][11:0]), 5);
        check(mem[d[11:2] + 1][15:14] == 2'b11, "R5", "sof eof bits", 32'(mem[d[11:2] + 1][15:14]), 3);
        check(mem[d[11:2] + 1][31:22] == 10'b0000000001, "R7", "type flag only",
              32'(mem[d[11:2] + 1][31:22]), 1);
      end
      if (lens[k] == 129)
        check(mem[d[11:2] + 1] == 32'h0000_4000, "R4", "first buffer status of long frame",
              mem[d[11:2] + 1], 32'h4000);
      releaseAll();
    end

    // random frames
    for (int k = 0; k < 20; k++) begin
      sendFrame(int'($urandom_range(300, 1)), 6'($urandom));
      releaseAll();
    end

    // R10: fill ring without release, then refused at frame start
    sendFrame(300, 6'b000001);
    sendFrame(300, 6'b000010);
    d = expPtr;
    sendFrame(200, 6'b000100);
    check(ovrFlag === 1'b1, "R10", "overrun raised", 32'(ovrFlag), 1);
    repeat (5) @(negedge clk);
    check(ovrFlag === 1'b1, "R10", "overrun sticky", 32'(ovrFlag), 1);
    ovrClr = 1'b1;
    @(negedge clk);
    ovrClr = 1'b0;
    expOvr = 1'b0;
    check(ovrFlag === 1'b0, "R10", "overrun cleared", 32'(ovrFlag), 0);
    // release only current descriptor: mid-frame refusal
    mem[d[11:2]][0] = 1'b0;
    expMem[d[11:2]][0] = 1'b0;
    sendFrame(300, 6'b001000);
    check(ovrFlag === 1'b1, "R10", "mid-frame overrun", 32'(ovrFlag), 1);
    ovrClr = 1'b1;
    @(negedge clk);
    ovrClr = 1'b0;
    expOvr = 1'b0;
    releaseAll();
    d = expPtr;
    sendFrame(60, 6'b010000);
    check(mem[d[11:2]][0] === 1'b1, "R10", "refused descriptor reused", 32'(mem[d[11:2]][0]), 1);

    // R11: new base with low bits set, three buffers at 0x800
    setupRing(32'h200, 3, 32'h800);
    writeBase(32'h205);
    sendFrame(10, 6'b100001);
    check(mem[32'h200 >> 2] === 32'h0000_0801, "R11", "first descriptor of new ring",
          mem[32'h200 >> 2], 32'h801);
    releaseAll();
    for (int k = 0; k < 6; k++) begin
      sendFrame(int'($urandom_range(260, 1)), 6'($urandom));
      releaseAll();
    end

    check(clash == 0, "R12", "ready during memory access", 32'(clash), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule